// File: doc/BRIEF.md
# Programmable Parallel Port Controller

This block connects a processor bus to three 8-bit parallel ports, called A, B and C. Port C is handled as two 4-bit halves. The processor reaches the block through an active-low chip select, a 2-bit address and active-low read and write strobes. Data moves on separate 8-bit input and output buses.

The block works in plain input/output mode only, with no handshaking. A write to a port address loads that port's output latch. A read returns the value of the addressed port. Each port group (A, B, upper C and lower C) is an input or an output, and a mode word written to the control address chooses this. A second form of control word, at the same address, sets or clears any single bit of Port C. That same form also drives two interrupt-enable mask flops. Each mask is tied to one Port C bit position. Both masks clear on reset and on every mode word.

Pins are split into `_in`, `_out` and `_oe` vectors, so the chip's pad ring provides the tristate buffers. Everything runs on one clock with a synchronous active-high reset.

Top module: `pario_ctrl`

## Requirements
- R1: Reset (synchronous, active high) leaves every group configured as input, so all `_oe` bits are 0. It also clears every output latch, both mask flops and `dout`.
- R2: A write to address 3 with data bit 7 = 1 is a mode word. Bit 4 = 1 makes Port A an input, bit 1 = 1 makes Port B an input, bit 3 = 1 makes upper C an input and bit 0 = 1 makes lower C an input. A 0 in any of these bits makes that group an output. Bits 6, 5 and 2 have no effect. The mode word clears all three output latches.
- R3: A write to address 0, 1 or 2 loads the whole data byte into the latch of Port A, B or C. The new value appears on `pa_out`, `pb_out` or `pc_out` after the clock edge that samples the write.
- R4: A read (chip select and `rd_n` low) is captured at a clock edge and shows on `dout` after that edge. For an output group, `dout` carries the latch value. For an input group, it carries the live pin value from that edge. When no read is in progress, `dout` is 0.
- R5: A read of address 3 returns 0x00.
- R6: A write to address 3 with bit 7 = 0 changes only one bit of `pc_out`. Bits 3..2..1 select the bit, with bit 1 as the least significant select bit. Bit 0 gives the new value (1 = set, 0 = clear). Bits 6..4 are ignored.
- R7: `irq_en[0]` takes the value of bit 0 of any bit command that selects Port C bit 4. `irq_en[1]` does the same for bit commands that select Port C bit 2. Both masks clear on every mode word.
- R8: While `cs_n` is high, the strobes have no effect on latches, masks or direction. `dout` is then 0.
- R9: Within each group, every `_oe` bit is 1 exactly when that group is configured as an output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| cs_n | input | 1 | Chip select, active low |
| rd_n | input | 1 | Read strobe, active low |
| wr_n | input | 1 | Write strobe, active low |
| addr | input | 2 | 0 = Port A, 1 = Port B, 2 = Port C, 3 = control |
| din | input | 8 | Write data from the processor |
| dout | output | 8 | Registered read data |
| pa_in | input | 8 | Port A pin values |
| pa_out | output | 8 | Port A output latch |
| pa_oe | output | 8 | Port A per-bit output enable |
| pb_in | input | 8 | Port B pin values |
| pb_out | output | 8 | Port B output latch |
| pb_oe | output | 8 | Port B per-bit output enable |
| pc_in | input | 8 | Port C pin values |
| pc_out | output | 8 | Port C output latch |
| pc_oe | output | 8 | Port C per-bit output enable (upper and lower halves independent) |
| irq_en | output | 2 | Interrupt-enable masks, tied to Port C bits 4 and 2 |

## Verification
The assertions assume that the processor never drives `rd_n` and `wr_n` low together. They also assume that a strobe is sampled once per clock, so a strobe held low for several cycles acts on each of those cycles. The bench drives every bus operation as a single-cycle strobe, starting after a clock edge, and it never lowers both strobes at once. The pin inputs only change outside the cycle in which a read is sampled. The random phase keeps chip select, address and data arbitrary within these rules.

// File: rtl/pario_pkg.sv
package pario_pkg;

  typedef enum logic [1:0] {
    SEL_PA   = 2'b00,
    SEL_PB   = 2'b01,
    SEL_PC   = 2'b10,
    SEL_CTRL = 2'b11
  } port_sel_e;

  // index of each group inside the direction vector (1 = input)
  localparam int unsigned DIR_A  = 0;
  localparam int unsigned DIR_CL = 1;
  localparam int unsigned DIR_B  = 2;
  localparam int unsigned DIR_CU = 3;
  localparam int unsigned N_GRP  = 4;

  typedef struct packed {
    logic mode_wr;
    logic bit_wr;
    logic a_wr;
    logic b_wr;
    logic c_wr;
  } wr_cmd_t;

endpackage

// File: rtl/pario_bus_decode.sv
module pario_bus_decode
  import pario_pkg::*;
#(
  parameter int unsigned DW    = 8,
  parameter int unsigned SEL_W = $clog2(DW)
) (
  input  logic                    cs_n,
  input  logic                    rd_n,
  input  logic                    wr_n,
  input  logic [1:0]              addr,
  input  logic [DW-1:0]           din,
  output wr_cmd_t                 cmd,
  output logic [N_GRP-1:0]        dir_next,
  output logic [SEL_W-1:0]        bit_idx,
  output logic                    bit_val,
  output logic [DW-1:0]           wdata,
  output logic                    rd_en,
  output port_sel_e               rd_sel
);

  logic      acc_wr;
  port_sel_e sel;

  always_comb begin
    sel    = port_sel_e'(addr);
    acc_wr = !cs_n && !wr_n;
    rd_en  = !cs_n && !rd_n;
    rd_sel = sel;

    cmd.a_wr    = acc_wr && (sel == SEL_PA);
    cmd.b_wr    = acc_wr && (sel == SEL_PB);
    cmd.c_wr    = acc_wr && (sel == SEL_PC);
    cmd.mode_wr = acc_wr && (sel == SEL_CTRL) &&  din[DW-1];
    cmd.bit_wr  = acc_wr && (sel == SEL_CTRL) && !din[DW-1];

    // direction field of a mode word (1 = input)
    dir_next         = '0;
    dir_next[DIR_A]  = din[4];
    dir_next[DIR_CU] = din[3];
    dir_next[DIR_B]  = din[1];
    dir_next[DIR_CL] = din[0];

    // single-bit command: select in bits above the value bit
    bit_idx = din[SEL_W:1];
    bit_val = din[0];
    wdata   = din;
  end

endmodule

// File: rtl/pario_dir_reg.sv
module pario_dir_reg
  import pario_pkg::*;
(
  input  logic             clk,
  input  logic             rst,
  input  logic             load,
  input  logic [N_GRP-1:0] dir_next,
  output logic [N_GRP-1:0] dir_in
);

  always_ff @(posedge clk) begin
    if (rst)       dir_in <= '1;
    else if (load) dir_in <= dir_next;
  end

endmodule

// File: rtl/pario_out_latch.sv
module pario_out_latch #(
  parameter int unsigned W      = 8,
  parameter bit          BSR_EN = 1'b0,
  parameter int unsigned SEL_W  = $clog2(W)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             clr,
  input  logic             load,
  input  logic [W-1:0]     wdata,
  input  logic             bit_wr,
  input  logic [SEL_W-1:0] bit_idx,
  input  logic             bit_val,
  output logic [W-1:0]     q
);

  always_ff @(posedge clk) begin
    if (rst || clr)               q <= '0;
    else if (load)                q <= wdata;
    else if (BSR_EN && bit_wr)    q[bit_idx] <= bit_val;
  end

endmodule

// File: rtl/pario_mask_bank.sv
module pario_mask_bank #(
  parameter int unsigned              N_MASK   = 2,
  parameter int unsigned              SEL_W    = 3,
  parameter logic [N_MASK*SEL_W-1:0]  MASK_POS = {3'd2, 3'd4}
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              clr,
  input  logic              bit_wr,
  input  logic [SEL_W-1:0]  bit_idx,
  input  logic              bit_val,
  output logic [N_MASK-1:0] en
);

  for (genvar i = 0; i < N_MASK; i++) begin : g_mask
    localparam logic [SEL_W-1:0] POS = MASK_POS[i*SEL_W +: SEL_W];
    always_ff @(posedge clk) begin
      if (rst || clr)                     en[i] <= 1'b0;
      else if (bit_wr && bit_idx == POS)  en[i] <= bit_val;
    end
  end

endmodule

// File: rtl/pario_read_path.sv
module pario_read_path
  import pario_pkg::*;
#(
  parameter int unsigned DW = 8,
  localparam int unsigned NIB = DW / 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             rd_en,
  input  port_sel_e        rd_sel,
  input  logic [N_GRP-1:0] dir_in,
  input  logic [DW-1:0]    a_q,
  input  logic [DW-1:0]    b_q,
  input  logic [DW-1:0]    c_q,
  input  logic [DW-1:0]    pa_in,
  input  logic [DW-1:0]    pb_in,
  input  logic [DW-1:0]    pc_in,
  output logic [DW-1:0]    dout
);

  logic [DW-1:0] a_view, b_view, c_view, sel_view;

  always_comb begin
    a_view = dir_in[DIR_A] ? pa_in : a_q;
    b_view = dir_in[DIR_B] ? pb_in : b_q;
    c_view[DW-1:NIB] = dir_in[DIR_CU] ? pc_in[DW-1:NIB] : c_q[DW-1:NIB];
    c_view[NIB-1:0]  = dir_in[DIR_CL] ? pc_in[NIB-1:0]  : c_q[NIB-1:0];
    unique case (rd_sel)
      SEL_PA:   sel_view = a_view;
      SEL_PB:   sel_view = b_view;
      SEL_PC:   sel_view = c_view;
      default:  sel_view = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst)        dout <= '0;
    else if (rd_en) dout <= sel_view;
    else            dout <= '0;
  end

endmodule

// File: rtl/pario_ctrl.sv
module pario_ctrl
  import pario_pkg::*;
#(
  parameter int unsigned DW     = 8,
  parameter int unsigned N_MASK = 2,
  localparam int unsigned SEL_W = $clog2(DW),
  localparam int unsigned NIB   = DW / 2,
  parameter logic [N_MASK*SEL_W-1:0] MASK_POS = {3'd2, 3'd4}
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cs_n,
  input  logic              rd_n,
  input  logic              wr_n,
  input  logic [1:0]        addr,
  input  logic [DW-1:0]     din,
  output logic [DW-1:0]     dout,
  input  logic [DW-1:0]     pa_in,
  output logic [DW-1:0]     pa_out,
  output logic [DW-1:0]     pa_oe,
  input  logic [DW-1:0]     pb_in,
  output logic [DW-1:0]     pb_out,
  output logic [DW-1:0]     pb_oe,
  input  logic [DW-1:0]     pc_in,
  output logic [DW-1:0]     pc_out,
  output logic [DW-1:0]     pc_oe,
  output logic [N_MASK-1:0] irq_en
);

  wr_cmd_t          cmd;
  logic [N_GRP-1:0] dir_next, dir_in;
  logic [SEL_W-1:0] bit_idx;
  logic             bit_val;
  logic [DW-1:0]    wdata;
  logic             rd_en;
  port_sel_e        rd_sel;

  pario_bus_decode #(.DW(DW), .SEL_W(SEL_W)) u_dec (
    .cs_n(cs_n), .rd_n(rd_n), .wr_n(wr_n), .addr(addr), .din(din),
    .cmd(cmd), .dir_next(dir_next), .bit_idx(bit_idx), .bit_val(bit_val),
    .wdata(wdata), .rd_en(rd_en), .rd_sel(rd_sel)
  );

  pario_dir_reg u_dir (
    .clk(clk), .rst(rst), .load(cmd.mode_wr), .dir_next(dir_next), .dir_in(dir_in)
  );

  pario_out_latch #(.W(DW), .BSR_EN(1'b0)) u_lat_a (
    .clk(clk), .rst(rst), .clr(cmd.mode_wr), .load(cmd.a_wr), .wdata(wdata),
    .bit_wr(1'b0), .bit_idx(bit_idx), .bit_val(bit_val), .q(pa_out)
  );

  pario_out_latch #(.W(DW), .BSR_EN(1'b0)) u_lat_b (
    .clk(clk), .rst(rst), .clr(cmd.mode_wr), .load(cmd.b_wr), .wdata(wdata),
    .bit_wr(1'b0), .bit_idx(bit_idx), .bit_val(bit_val), .q(pb_out)
  );

  pario_out_latch #(.W(DW), .BSR_EN(1'b1)) u_lat_c (
    .clk(clk), .rst(rst), .clr(cmd.mode_wr), .load(cmd.c_wr), .wdata(wdata),
    .bit_wr(cmd.bit_wr), .bit_idx(bit_idx), .bit_val(bit_val), .q(pc_out)
  );

  pario_mask_bank #(.N_MASK(N_MASK), .SEL_W(SEL_W), .MASK_POS(MASK_POS)) u_mask (
    .clk(clk), .rst(rst), .clr(cmd.mode_wr), .bit_wr(cmd.bit_wr),
    .bit_idx(bit_idx), .bit_val(bit_val), .en(irq_en)
  );

  pario_read_path #(.DW(DW)) u_rd (
    .clk(clk), .rst(rst), .rd_en(rd_en), .rd_sel(rd_sel), .dir_in(dir_in),
    .a_q(pa_out), .b_q(pb_out), .c_q(pc_out),
    .pa_in(pa_in), .pb_in(pb_in), .pc_in(pc_in), .dout(dout)
  );

  always_comb begin
    pa_oe = {DW{~dir_in[DIR_A]}};
    pb_oe = {DW{~dir_in[DIR_B]}};
    pc_oe = {{NIB{~dir_in[DIR_CU]}}, {NIB{~dir_in[DIR_CL]}}};
  end

endmodule

// File: rtl/pario_checker.sv
module pario_checker #(
  parameter int unsigned DW     = 8,
  parameter int unsigned N_MASK = 2
) (
  input logic              clk,
  input logic              rst,
  input logic              cs_n,
  input logic              rd_n,
  input logic              wr_n,
  input logic [1:0]        addr,
  input logic [DW-1:0]     din,
  input logic [DW-1:0]     dout,
  input logic [DW-1:0]     pa_out,
  input logic [DW-1:0]     pa_oe,
  input logic [DW-1:0]     pb_out,
  input logic [DW-1:0]     pb_oe,
  input logic [DW-1:0]     pc_out,
  input logic [DW-1:0]     pc_oe,
  input logic [N_MASK-1:0] irq_en
);

  localparam int unsigned NIB = DW / 2;

  assert_reset_state_R1: assert property (@(posedge clk)
    rst |=> (pa_oe == '0 && pb_oe == '0 && pc_oe == '0 && pa_out == '0 &&
             pb_out == '0 && pc_out == '0 && irq_en == '0 && dout == '0));

  assert_mode_clears_R2: assert property (@(posedge clk) disable iff (rst)
    (!cs_n && !wr_n && addr == 2'b11 && din[DW-1]) |=>
      (pa_out == '0 && pb_out == '0 && pc_out == '0 && irq_en == '0));

  assert_ctrl_read_zero_R5: assert property (@(posedge clk) disable iff (rst)
    (!cs_n && !rd_n && addr == 2'b11) |=> dout == '0);

  assert_single_bit_R6: assert property (@(posedge clk) disable iff (rst)
    (!cs_n && !wr_n && addr == 2'b11 && !din[DW-1]) |=>
      ($countones(pc_out ^ $past(pc_out)) <= 1 && $stable(pa_out) && $stable(pb_out)));

  assert_mask_only_bsr_R7: assert property (@(posedge clk) disable iff (rst)
    !(!cs_n && !wr_n && addr == 2'b11) |=> $stable(irq_en));

  assert_deselect_quiet_R8: assert property (@(posedge clk) disable iff (rst)
    cs_n |=> ($stable(pa_out) && $stable(pb_out) && $stable(pc_out) &&
              $stable(irq_en) && $stable(pa_oe) && dout == '0));

  assert_group_oe_R9: assert property (@(posedge clk) disable iff (rst)
    ((pa_oe == '0 || pa_oe == '1) && (pb_oe == '0 || pb_oe == '1) &&
     (pc_oe[NIB-1:0] == '0 || pc_oe[NIB-1:0] == '1) &&
     (pc_oe[DW-1:NIB] == '0 || pc_oe[DW-1:NIB] == '1)));

endmodule

bind pario_ctrl pario_checker #(.DW(DW), .N_MASK(N_MASK)) i_pario_checker (.*);

// File: tb/test_pario_ctrl.sv
module test_pario_ctrl;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       cs_n = 1'b1, rd_n = 1'b1, wr_n = 1'b1;
  logic [1:0] addr = 2'b00;
  logic [7:0] din = 8'h00;
  logic [7:0] dout;
  logic [7:0] pa_in = 8'h00, pb_in = 8'h00, pc_in = 8'h00;
  logic [7:0] pa_out, pa_oe, pb_out, pb_oe, pc_out, pc_oe;
  logic [1:0] irq_en;

  always #5 clk = ~clk;

  pario_ctrl i_pario_ctrl (
    .clk(clk), .rst(rst), .cs_n(cs_n), .rd_n(rd_n), .wr_n(wr_n), .addr(addr),
    .din(din), .dout(dout), .pa_in(pa_in), .pa_out(pa_out), .pa_oe(pa_oe),
    .pb_in(pb_in), .pb_out(pb_out), .pb_oe(pb_oe), .pc_in(pc_in),
    .pc_out(pc_out), .pc_oe(pc_oe), .irq_en(irq_en)
  );

  int checks = 0;
  int errors = 0;
  bit started = 0;
  bit done = 0;

  // behavioural reference state
  logic [7:0] m_a, m_b, m_c, m_dout;
  bit         m_ain, m_bin, m_cuin, m_clin;   // 1 = input
  logic [1:0] m_irq;

  task automatic check(input bit ok, input string tag, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
    end
  endtask

  function automatic logic [7:0] model_read(input logic [1:0] a);
    logic [7:0] v;
    case (a)
      2'd0: v = m_ain ? pa_in : m_a;
      2'd1: v = m_bin ? pb_in : m_b;
      2'd2: begin
        v[7:4] = m_cuin ? pc_in[7:4] : m_c[7:4];
        v[3:0] = m_clin ? pc_in[3:0] : m_c[3:0];
      end
      default: v = 8'h00;
    endcase
    return v;
  endfunction

  always @(posedge clk) begin
    started <= 1'b1;
    if (rst) begin
      m_a = 0; m_b = 0; m_c = 0; m_dout = 0; m_irq = 0;
      m_ain = 1; m_bin = 1; m_cuin = 1; m_clin = 1;
    end else begin
      m_dout = (!cs_n && !rd_n) ? model_read(addr) : 8'h00;
      if (!cs_n && !wr_n) begin
        case (addr)
          2'd0: m_a = din;
          2'd1: m_b = din;
          2'd2: m_c = din;
          default: begin
            if (din[7]) begin
              m_ain = din[4]; m_cuin = din[3]; m_bin = din[1]; m_clin = din[0];
              m_a = 0; m_b = 0; m_c = 0; m_irq = 0;
            end else begin
              m_c[din[3:1]] = din[0];
              if (din[3:1] == 3'd4) m_irq[0] = din[0];
              if (din[3:1] == 3'd2) m_irq[1] = din[0];
            end
          end
        endcase
      end
    end
  end

  // per-clock comparison against the reference
  always @(negedge clk) begin
    if (started && !done) begin
      check(pa_out == m_a, "R3 pa_out", pa_out, m_a);
      check(pb_out == m_b, "R3 pb_out", pb_out, m_b);
      check(pc_out == m_c, "R3/R6 pc_out", pc_out, m_c);
      check(dout == m_dout, "R4 dout", dout, m_dout);
      check(pa_oe == {8{~m_ain}}, "R9 pa_oe", pa_oe, {8{~m_ain}});
      check(pb_oe == {8{~m_bin}}, "R9 pb_oe", pb_oe, {8{~m_bin}});
      check(pc_oe == {{4{~m_cuin}}, {4{~m_clin}}}, "R9 pc_oe", pc_oe, {{4{~m_cuin}}, {4{~m_clin}}});
      check(irq_en == m_irq, "R7 irq_en", {6'b0, irq_en}, {6'b0, m_irq});
    end
  end

  task automatic bus_wr(input logic [1:0] a, input logic [7:0] d, input bit sel = 1);
    @(posedge clk); #3;
    cs_n = !sel; wr_n = 1'b0; addr = a; din = d;
    @(posedge clk); #3;
    cs_n = 1'b1; wr_n = 1'b1;
  endtask

  task automatic bus_rd(input logic [1:0] a, input bit sel = 1);
    @(posedge clk); #3;
    cs_n = !sel; rd_n = 1'b0; addr = a;
    @(posedge clk); #3;
    cs_n = 1'b1; rd_n = 1'b1;
  endtask

  task automatic finish_run();
    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  initial begin
    #1_500_000;
    errors++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    repeat (3) @(posedge clk);
    #3 rst = 1'b0;
    @(negedge clk);
    check(pa_oe == 8'h00 && pb_oe == 8'h00 && pc_oe == 8'h00, "R1 oe after reset", pa_oe, 8'h00);
    check(pc_out == 8'h00 && irq_en == 2'b00 && dout == 8'h00, "R1 state after reset", pc_out, 8'h00);

    bus_wr(2'd3, 8'h80);
    @(negedge clk);
    check(pa_oe == 8'hFF && pc_oe == 8'hFF, "R2/R9 all output", pa_oe, 8'hFF);

    bus_wr(2'd0, 8'h5A);
    bus_wr(2'd1, 8'hC3);
    bus_wr(2'd2, 8'h81);
    @(negedge clk);
    check(pa_out == 8'h5A, "R3 port A write", pa_out, 8'h5A);
    check(pb_out == 8'hC3, "R3 port B write", pb_out, 8'hC3);

    pa_in = 8'h00; pb_in = 8'hFF; pc_in = 8'h0F;
    bus_rd(2'd0);
    @(negedge clk);
    check(dout == 8'h5A, "R4 output group reads latch", dout, 8'h5A);
    bus_rd(2'd3);
    @(negedge clk);
    check(dout == 8'h00, "R5 control read", dout, 8'h00);

    bus_wr(2'd3, 8'h09);            // bit 4 set
    @(negedge clk);
    check(pc_out == 8'h91, "R6 set bit 4", pc_out, 8'h91);
    check(irq_en == 2'b01, "R7 mask A set", {6'b0, irq_en}, 8'h01);
    bus_wr(2'd3, 8'h05);            // bit 2 set
    bus_wr(2'd3, 8'h08);            // bit 4 clear
    @(negedge clk);
    check(pc_out == 8'h85, "R6 clear bit 4", pc_out, 8'h85);
    check(irq_en == 2'b10, "R7 mask A clear, B set", {6'b0, irq_en}, 8'h02);
    bus_wr(2'd3, 8'h7E);            // D6..D4 junk, bit 7 clear
    @(negedge clk);
    check(pc_out == 8'h05, "R6 high bits ignored", pc_out, 8'h05);

    bus_wr(2'd0, 8'hFF, 0);
    bus_wr(2'd3, 8'h9B, 0);
    @(negedge clk);
    check(pa_out == 8'h5A && pa_oe == 8'hFF, "R8 deselected writes ignored", pa_out, 8'h5A);
    check(irq_en == 2'b10, "R8 masks kept", {6'b0, irq_en}, 8'h02);
    bus_rd(2'd0, 0);
    @(negedge clk);
    check(dout == 8'h00, "R8 deselected read", dout, 8'h00);

    bus_wr(2'd3, 8'h9B);
    @(negedge clk);
    check(pa_out == 8'h00 && pc_out == 8'h00, "R2 mode clears latches", pc_out, 8'h00);
    check(irq_en == 2'b00, "R7 mode clears masks", {6'b0, irq_en}, 8'h00);
    check(pa_oe == 8'h00 && pc_oe == 8'h00, "R9 all input", pc_oe, 8'h00);
    pa_in = 8'h3C;
    bus_rd(2'd0);
    @(negedge clk);
    check(dout == 8'h3C, "R4 input group reads pins", dout, 8'h3C);

    bus_wr(2'd3, 8'h8A);            // A out, B in, C upper in, C lower out
    bus_wr(2'd2, 8'hA5);
    pc_in = 8'h3C;
    bus_rd(2'd2);
    @(negedge clk);
    check(dout == 8'h35, "R4 mixed port C read", dout, 8'h35);
    check(pc_oe == 8'h0F, "R9 split port C", pc_oe, 8'h0F);

    bus_wr(2'd3, 8'hE4);            // mode-select bits set, all groups output
    @(negedge clk);
    check(pa_oe == 8'hFF && pc_oe == 8'hFF, "R2 mode-select bits ignored", pa_oe, 8'hFF);

    for (int cfg = 0; cfg < 16; cfg++) begin
      bus_wr(2'd3, {3'b100, cfg[3], cfg[2], 1'b0, cfg[1], cfg[0]});
      pa_in = 8'(cfg * 17); pb_in = ~8'(cfg); pc_in = 8'(cfg * 29);
      bus_wr(2'd0, 8'(cfg + 8'h40));
      bus_wr(2'd2, 8'(cfg * 13));
      for (int a = 0; a < 4; a++) bus_rd(2'(a));
    end

    for (int i = 0; i < 3000; i++) begin
      @(posedge clk); #3;
      pa_in = 8'($urandom); pb_in = 8'($urandom); pc_in = 8'($urandom);
      cs_n = ($urandom % 8) == 0;
      addr = 2'($urandom);
      din  = 8'($urandom);
      if ($urandom % 2) begin rd_n = 1'b0; wr_n = 1'b1; end
      else begin
        rd_n = 1'b1; wr_n = 1'b0;
        if (addr == 2'd3 && ($urandom % 4) != 0) din[7] = 1'b0;
      end
      @(posedge clk); #3;
      cs_n = 1'b1; rd_n = 1'b1; wr_n = 1'b1;
    end

    @(negedge clk);
    finish_run();
  end

endmodule